// File: doc/BRIEF.md
# Two-Level DMA Channel Arbiter

This block chooses which of sixteen DMA channels is served next. Each channel gives it three bits: a pending request, an enable, and a class bit that puts the channel either in the fixed class or in the rotating (round-robin) class. Only one channel is served at a time. The block registers a one-hot grant together with the index of the granted channel, and keeps that grant until the transfer engine pulses a completion input. Only then does it choose again.

A fixed-class request always beats a rotating-class request. Inside the fixed class the highest-numbered eligible channel wins every time. Inside the rotating class a start pointer moves downward. It begins at channel 15 after reset. After a rotating grant to channel k the search starts at k-1, and it wraps from 0 to 15. Fixed grants leave the pointer alone. Descriptor handling, address generation and bus traffic belong to neighbouring blocks.

Top module: `dma_chan_arb`

## Requirements
- R1: While reset is active and right after it, `gnt_o` is all zeros and `gnt_vld_o` is 0. The rotating search pointer starts at channel 15.
- R2: `gnt_o` has at most one bit set, and bit i means channel i. `gnt_vld_o` is 1 exactly when a bit is set. `gnt_id_o` is the index of that bit.
- R3: A channel is eligible when `req_i[i]` and `en_i[i]` are both 1. `fixed_i[i]`=1 puts channel i in the fixed class and 0 puts it in the rotating class. When any fixed-class channel is eligible, the grant goes to a fixed-class channel.
- R4: Among eligible fixed-class channels, the one with the highest number is granted on every decision.
- R5: Among eligible rotating-class channels, the search starts at the start pointer and moves down through 0, then wraps to 15. After a rotating grant to channel k the pointer becomes k-1, or 15 when k is 0. A fixed grant leaves the pointer unchanged.
- R6: A decision is made on a rising edge when no grant is held, or when `done_i` is 1. The result shows on the outputs in the following cycle. While a grant is held and `done_i` is 0, the grant does not change, whatever the requests do.
- R7: A channel that is disabled or not requesting is never granted. When no channel is eligible at a decision, the grant becomes all zeros.
- R8: `done_i` has no effect while no grant is held. Neither the next grant nor the rotating pointer changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Pending request, one bit per channel |
| en_i | input | 16 | Channel enable, one bit per channel |
| fixed_i | input | 16 | Class select per channel, 1 = fixed, 0 = rotating |
| done_i | input | 1 | Pulse: the served channel finished its transfer unit |
| gnt_o | output | 16 | One-hot grant, all zeros when idle |
| gnt_id_o | output | 4 | Index of the granted channel, 0 when idle |
| gnt_vld_o | output | 1 | A grant is held |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples the stimulus. This holds for a new grant out of idle, for the grant that replaces the held one on `done_i`, and for the zero grant when nothing is eligible. A hold shows as an unchanged grant on that same next cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and compares all three outputs on the next falling edge. The expected grant for each step was worked out by hand from the pointer history of the steps before it. The rotating-pointer rules (R5, R8) are therefore checked only through which channel wins afterwards.

// File: rtl/dca_pkg.sv
package dca_pkg;

    // Step a downward rotation pointer, wrapping 0 to n-1
    function automatic logic [7:0] dec_wrap(input logic [7:0] idx, input int n);
        if (idx == 8'd0) begin
            return 8'(n - 1);
        end
        return idx - 8'd1;
    endfunction

endpackage

// File: rtl/dca_hi_pick.sv
// Finds the highest set bit of a vector
module dca_hi_pick #(
    parameter int N = 16,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
    parameter int NCH = 16,
    localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] en_i,
    input  logic [NCH-1:0] fixed_i,
    input  logic           done_i,
    output logic [NCH-1:0] gnt_o,
    output logic [IDW-1:0] gnt_id_o,
    output logic           gnt_vld_o
);

    typedef struct packed {
        logic [NCH-1:0] gnt;
        logic [IDW-1:0] id;
        logic [IDW-1:0] start;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NCH-1:0] elig;
    logic [NCH-1:0] fix_req;
    logic [NCH-1:0] rr_req;
    logic [NCH-1:0] rr_low_mask;
    logic [NCH-1:0] rr_low_req;
    logic           fix_found, low_found, all_found;
    logic [IDW-1:0] fix_idx, low_idx, all_idx;
    logic           decide;

    assign elig       = req_i & en_i;
    assign fix_req    = elig & fixed_i;
    assign rr_req     = elig & ~fixed_i;
    assign rr_low_req = rr_req & rr_low_mask;

    // Channels at or below the start pointer are searched first
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            rr_low_mask[i] = (IDW'(i) <= st_q.start);
        end
    end

    dca_hi_pick #(.N(NCH)) u_pick_fix (
        .vec_i   (fix_req),
        .found_o (fix_found),
        .idx_o   (fix_idx)
    );

    dca_hi_pick #(.N(NCH)) u_pick_low (
        .vec_i   (rr_low_req),
        .found_o (low_found),
        .idx_o   (low_idx)
    );

    dca_hi_pick #(.N(NCH)) u_pick_all (
        .vec_i   (rr_req),
        .found_o (all_found),
        .idx_o   (all_idx)
    );

    assign decide = (st_q.gnt == '0) || done_i;

    always_comb begin
        st_d = st_q;
        if (decide) begin
            st_d.gnt = '0;
            st_d.id  = '0;
            if (fix_found) begin
                st_d.gnt[fix_idx] = 1'b1;
                st_d.id           = fix_idx;
            end else if (low_found) begin
                st_d.gnt[low_idx] = 1'b1;
                st_d.id           = low_idx;
                st_d.start        = IDW'(dca_pkg::dec_wrap(8'(low_idx), NCH));
            end else if (all_found) begin
                st_d.gnt[all_idx] = 1'b1;
                st_d.id           = all_idx;
                st_d.start        = IDW'(dca_pkg::dec_wrap(8'(all_idx), NCH));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gnt   <= '0;
            st_q.id    <= '0;
            st_q.start <= IDW'(NCH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o     = st_q.gnt;
    assign gnt_id_o  = st_q.id;
    assign gnt_vld_o = |st_q.gnt;

endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
    parameter int NCH = 16,
    localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req_i,
    input logic [NCH-1:0] en_i,
    input logic [NCH-1:0] fixed_i,
    input logic           done_i,
    input logic [NCH-1:0] gnt_o,
    input logic [IDW-1:0] gnt_id_o,
    input logic           gnt_vld_o
);

    logic upd;
    assign upd = (gnt_o == '0) || done_i;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R2

    AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> gnt_o[gnt_id_o]); // R2

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && !done_i) |=> $stable(gnt_o)); // R6

    AST_FIXED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ((req_i & en_i & fixed_i) != '0)) |=> ((gnt_o & $past(fixed_i)) != '0)); // R3

    AST_GNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ((gnt_o & ~$past(req_i & en_i)) == '0)); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ((req_i & en_i) == '0)) |=> (gnt_o == '0)); // R7

endmodule

bind dma_chan_arb dca_checker #(.NCH(NCH)) u_dca_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .en_i      (en_i),
    .fixed_i   (fixed_i),
    .done_i    (done_i),
    .gnt_o     (gnt_o),
    .gnt_id_o  (gnt_id_o),
    .gnt_vld_o (gnt_vld_o)
);

// File: tb/dma_chan_arb_test.sv
module dma_chan_arb_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    typedef struct packed {
        logic [15:0] req;
        logic [15:0] en;
        logic [15:0] fix;
        logic        done;
        logic        vld;
        logic [3:0]  id;
        logic [3:0]  tag;
    } vec_t;

    // Each row is applied for one rising edge, starting from reset (pointer at 15)
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd0,  4'd7}, // R7 nothing pending
        '{16'h0208, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd9,  4'd5}, // R5 start 15 -> 9
        '{16'h0208, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd9,  4'd6}, // R6 hold
        '{16'h1208, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd9,  4'd6}, // R6 higher request does not preempt
        '{16'h1208, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd3,  4'd5}, // R5 start 8 -> 3
        '{16'h1208, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd12, 4'd5}, // R5 start 2 wraps -> 12
        '{16'h1208, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd9,  4'd5}, // R5 start 11 -> 9
        '{16'h122A, 16'hFFFF, 16'h0022, 1'b1, 1'b1, 4'd5,  4'd3}, // R3 fixed 5 beats rotating 12
        '{16'h122A, 16'hFFFF, 16'h0022, 1'b1, 1'b1, 4'd5,  4'd4}, // R4 fixed highest again
        '{16'h1040, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd6,  4'd5}, // R5 pointer still 8 -> 6
        '{16'h1208, 16'hFFF7, 16'h0000, 1'b1, 1'b1, 4'd12, 4'd7}, // R7 disabled 3 skipped
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd0,  4'd7}, // R7 released, none pending
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd0,  4'd8}, // R8 done while idle
        '{16'h0001, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd0,  4'd5}, // R5 grant 0, pointer wraps to 15
        '{16'h8001, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd15, 4'd5}, // R5 start 15 -> 15
        '{16'h8001, 16'h7FFF, 16'h8000, 1'b1, 1'b1, 4'd0,  4'd7}, // R7 disabled fixed 15 loses
        '{16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd15, 4'd5}, // R5 all pending -> 15
        '{16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd14, 4'd5}, // R5 descending -> 14
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 4'd14, 4'd6}, // R6 hold after request drops
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd0,  4'd7}, // R7 release to idle
        '{16'h4080, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 4'd7,  4'd8}  // R8 done in idle, start 13 -> 7
    };

    logic        clk;
    logic        rst_n;
    logic [15:0] req_i;
    logic [15:0] en_i;
    logic [15:0] fixed_i;
    logic        done_i;
    logic [15:0] gnt_o;
    logic [3:0]  gnt_id_o;
    logic        gnt_vld_o;

    int n_chk;
    int n_bad;
    bit finished;

    dma_chan_arb uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .en_i      (en_i),
        .fixed_i   (fixed_i),
        .done_i    (done_i),
        .gnt_o     (gnt_o),
        .gnt_id_o  (gnt_id_o),
        .gnt_vld_o (gnt_vld_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check_out(input logic exp_vld, input logic [3:0] exp_id, input int tag);
        logic [15:0] exp_gnt;
        exp_gnt = exp_vld ? (16'd1 << exp_id) : 16'd0;
        n_chk++;
        if (gnt_o !== exp_gnt) begin
            n_bad++;
            $display("FAIL R%0d gnt_o actual %h expected %h", tag, gnt_o, exp_gnt);
        end
        n_chk++;
        if (gnt_vld_o !== exp_vld) begin
            n_bad++;
            $display("FAIL R%0d gnt_vld_o actual %b expected %b", tag, gnt_vld_o, exp_vld);
        end
        n_chk++;
        if (gnt_id_o !== (exp_vld ? exp_id : 4'd0)) begin
            n_bad++;
            $display("FAIL R%0d gnt_id_o actual %0d expected %0d", tag, gnt_id_o,
                     exp_vld ? exp_id : 4'd0);
        end
    endtask

    task automatic apply(input logic [15:0] r, input logic [15:0] e,
                         input logic [15:0] f, input logic d);
        req_i   = r;
        en_i    = e;
        fixed_i = f;
        done_i  = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        n_chk    = 0;
        n_bad    = 0;
        finished = 0;
        rst_n    = 1'b0;
        req_i    = '0;
        en_i     = '0;
        fixed_i  = '0;
        done_i   = 1'b0;
        repeat (3) @(negedge clk);
        check_out(1'b0, 4'd0, 1); // R1 outputs in reset
        rst_n = 1'b1;
        @(negedge clk);
        check_out(1'b0, 4'd0, 1); // R1 outputs after reset

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].req, VECS[v].en, VECS[v].fix, VECS[v].done);
            check_out(VECS[v].vld, VECS[v].id, int'(VECS[v].tag)); // R2 on every row
        end

        // R1: reset while channel 7 is held clears grant and returns pointer to 15
        rst_n = 1'b0;
        @(negedge clk);
        check_out(1'b0, 4'd0, 1); // R1 mid-operation reset
        req_i = '0;
        done_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        apply(16'h8001, 16'hFFFF, 16'h0000, 1'b0);
        check_out(1'b1, 4'd15, 1); // R1 pointer back at 15 (stale pointer would give 0)

        // R3: fixed channel 3 beats rotating 0 on the done edge
        apply(16'h0009, 16'hFFFF, 16'h0008, 1'b1);
        check_out(1'b1, 4'd3, 3); // R3

        // R4: two fixed channels, highest wins twice in a row
        apply(16'h0411, 16'hFFFF, 16'h0410, 1'b1);
        check_out(1'b1, 4'd10, 4); // R4
        apply(16'h0411, 16'hFFFF, 16'h0410, 1'b1);
        check_out(1'b1, 4'd10, 4); // R4

        // R5: fixed grants left pointer at 14: rotating {0,14} -> 14
        apply(16'h4001, 16'hFFFF, 16'h0000, 1'b1);
        check_out(1'b1, 4'd14, 5); // R5

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule